// File: doc/BRIEF.md
# ADC Start Trigger Qualifier

This block decides when a sampling sequencer may issue convert strobes. A start command arms it. Depending on the configuration, it then opens the sample enable at once or waits for a hardware trigger. The hardware trigger comes from a digital trigger pin or from the output bit of an external analog comparator. Either source is passed through a synchronizer before it is examined.

In edge mode, the first qualifying transition after the start locks sampling on until a stop arrives. Falling, rising or either transition can qualify. In level mode, sampling follows the trigger level: it runs while the level matches the selected polarity and pauses while it does not. Level mode with the either setting behaves like a software start. A stop returns the block to idle and clears any armed or triggered state. The sequencer reads the sample enable, and software or a status path can read the waiting flag.

Top module: `trig_qualifier`

## Requirements
- R1: After reset and while idle, sample_en_o and wait_o are both 0. The idle state is left only through a start command.
- R2: With hw_mode_i=0, a start_i pulse sampled at a clock edge sets sample_en_o=1 and wait_o=0 from that edge onward.
- R3: With hw_mode_i=1 and level_mode_i=0, a start sets wait_o=1 and sample_en_o=0.
  - dir_i encodes the qualifying edge: 2'b00 falling, 2'b01 rising, 2'b10 or 2'b11 either.
  - A qualifying edge on the trigger input raises sample_en_o (and drops wait_o) on the third clock edge after the input changes.
  - A transition in the other direction leaves the block waiting.
- R4: A qualifying edge that has already passed through the two-stage synchronizer before the start is sampled does not trigger the block.
- R5: Once edge mode has triggered, further changes on the trigger input leave sample_en_o at 1 until a stop.
- R6: With hw_mode_i=1, level_mode_i=1 and dir_i=2'b00, sample_en_o equals the inverse of the trigger input delayed by two clocks; with dir_i=2'b01 it equals the trigger input delayed by two clocks. In both cases wait_o is the inverse of sample_en_o while running.
- R7: Level mode with dir_i=2'b10 or 2'b11 acts as a software start: sample_en_o=1 from the start edge, whatever the trigger input does.
- R8: src_sel_i=0 selects dig_trig_i and src_sel_i=1 selects cmp_trig_i as the trigger input. Activity on the unselected input has no effect.
- R9: A stop_i pulse returns the block to idle (both outputs 0) at the next edge and has priority over a start in the same cycle. The next start waits for its trigger again.
- R10: hw_mode_i, level_mode_i, dir_i and src_sel_i are captured at the accepted start. Their later changes, and further start pulses while the block is not idle, have no effect until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| hw_mode_i | input | 1 | 0 software trigger, 1 hardware trigger |
| level_mode_i | input | 1 | 0 edge type, 1 level type |
| dir_i | input | 2 | 00 negative, 01 positive, 1x both |
| src_sel_i | input | 1 | 0 digital pin, 1 comparator bit |
| dig_trig_i | input | 1 | Asynchronous digital trigger pin |
| cmp_trig_i | input | 1 | Asynchronous analog comparator output |
| sample_en_o | output | 1 | Convert strobes permitted |
| wait_o | output | 1 | Armed and waiting for the trigger condition |

## Verification
The bench aims a falling edge to land fully synchronized just before the start. A design that honours stale edges would then begin sampling without a fresh trigger. It toggles the trigger after an edge has fired, which catches an edge mode that slides into level behaviour and drops the enable. It also drives start and stop in the same cycle, activity on the unselected source, and configuration changes while running. Each of these exposes a design that lets the wrong command, the wrong source or a live configuration steer the enable. Exact three-clock and two-clock latencies are checked, so an extra or missing synchronizer stage is visible.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_W   = $clog2(NUM_SRC);

  typedef enum logic [1:0] {
    DIR_FALL  = 2'b00,
    DIR_RISE  = 2'b01,
    DIR_ANY   = 2'b10,
    DIR_ANY_X = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_RUN,
    ST_GATED
  } st_e;

  typedef struct packed {
    logic             hw;
    logic             lvl;
    dir_e             dir;
    logic [SRC_W-1:0] src;
  } cfg_t;

  function automatic logic dir_is_any(dir_e d);
    return d[1];
  endfunction
endpackage

// File: rtl/trig_sync.sv
`timescale 1ns/1ps
module trig_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/trig_detect.sv
`timescale 1ns/1ps
module trig_detect
  import trig_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] sync_i,
  input  logic [SRC_W-1:0]   src_i,
  input  dir_e               dir_i,
  output logic               edge_o,
  output logic               lvl_o
);
  logic [NUM_SRC-1:0] prev_q;
  logic cur, prv, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  assign cur  = sync_i[src_i];
  assign prv  = prev_q[src_i];
  assign rise = cur & ~prv;
  assign fall = ~cur & prv;

  always_comb begin
    unique case (dir_i)
      DIR_FALL: begin edge_o = fall;        lvl_o = ~cur; end
      DIR_RISE: begin edge_o = rise;        lvl_o = cur;  end
      default:  begin edge_o = rise | fall; lvl_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/trig_ctrl.sv
`timescale 1ns/1ps
module trig_ctrl
  import trig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  cfg_t cfg_i,
  input  logic edge_i,
  input  logic lvl_i,
  output cfg_t cfg_o,
  output logic en_o,
  output logic wait_o
);
  st_e  st_q, st_d;
  cfg_t cfg_q;
  logic launch;

  assign launch = (st_q == ST_IDLE) && start_i && !stop_i;

  always_comb begin
    st_d = st_q;
    if (stop_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:
          if (start_i) begin
            if (!cfg_i.hw || (cfg_i.lvl && dir_is_any(cfg_i.dir))) st_d = ST_RUN;
            else if (cfg_i.lvl)                                     st_d = ST_GATED;
            else                                                    st_d = ST_ARMED;
          end
        ST_ARMED: if (edge_i) st_d = ST_RUN;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cfg_q <= '0;
    end else begin
      st_q <= st_d;
      if (launch) cfg_q <= cfg_i;
    end
  end

  always_comb begin
    en_o   = 1'b0;
    wait_o = 1'b0;
    unique case (st_q)
      ST_RUN:   en_o = 1'b1;
      ST_ARMED: wait_o = 1'b1;
      ST_GATED: begin en_o = lvl_i; wait_o = ~lvl_i; end
      default:  ;
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/trig_qualifier.sv
`timescale 1ns/1ps
module trig_qualifier
  import trig_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       hw_mode_i,
  input  logic       level_mode_i,
  input  logic [1:0] dir_i,
  input  logic       src_sel_i,
  input  logic       dig_trig_i,
  input  logic       cmp_trig_i,
  output logic       sample_en_o,
  output logic       wait_o
);
  logic [NUM_SRC-1:0] raw, synced;
  cfg_t cfg_in, cfg_act;
  logic edge_hit, lvl_ok;

  assign raw    = {cmp_trig_i, dig_trig_i};
  assign cfg_in = '{hw: hw_mode_i, lvl: level_mode_i, dir: dir_e'(dir_i), src: src_sel_i};

  trig_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  trig_detect u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(synced),
    .src_i (cfg_act.src),
    .dir_i (cfg_act.dir),
    .edge_o(edge_hit),
    .lvl_o (lvl_ok)
  );

  trig_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .stop_i (stop_i),
    .cfg_i  (cfg_in),
    .edge_i (edge_hit),
    .lvl_i  (lvl_ok),
    .cfg_o  (cfg_act),
    .en_o   (sample_en_o),
    .wait_o (wait_o)
  );
endmodule

// File: rtl/trig_qualifier_chk.sv
`timescale 1ns/1ps
module trig_qualifier_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       hw_mode_i,
  input logic       level_mode_i,
  input logic [1:0] dir_i,
  input logic       sample_en_o,
  input logic       wait_o
);
  logic idle;
  assign idle = !sample_en_o && !wait_o;

  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !start_i) |=> (!sample_en_o && !wait_o)); // R1

  AST_SW_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && !stop_i && !hw_mode_i) |=> (sample_en_o && !wait_o)); // R2

  AST_EDGE_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && !stop_i && hw_mode_i && !level_mode_i) |=> (wait_o && !sample_en_o)); // R3

  AST_EN_WAIT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_en_o && wait_o)); // R6

  AST_LVL_ANY_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && !stop_i && hw_mode_i && level_mode_i && dir_i[1]) |=> sample_en_o); // R7

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sample_en_o && !wait_o)); // R9
endmodule

bind trig_qualifier trig_qualifier_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .hw_mode_i   (hw_mode_i),
  .level_mode_i(level_mode_i),
  .dir_i       (dir_i),
  .sample_en_o (sample_en_o),
  .wait_o      (wait_o)
);

// File: tb/trig_qualifier_bench.sv
`timescale 1ns/1ps
module trig_qualifier_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, stop = 1'b0, hw = 1'b0, lvl = 1'b0, src = 1'b0;
  logic [1:0] dir = 2'b00;
  logic pin = 1'b0, cmp = 1'b0;
  logic en, wt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  trig_qualifier u_trig_qualifier (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .stop_i      (stop),
    .hw_mode_i   (hw),
    .level_mode_i(lvl),
    .dir_i       (dir),
    .src_sel_i   (src),
    .dig_trig_i  (pin),
    .cmp_trig_i  (cmp),
    .sample_en_o (en),
    .wait_o      (wt)
  );

  // reference model: 0 idle, 1 armed, 2 running, 3 level-gated
  int         m_st;
  logic       m_hw, m_lvl, m_src;
  logic [1:0] m_dir;
  logic [1:0] m_s1, m_s2, m_prev;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_hw = 0; m_lvl = 0; m_src = 0; m_dir = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin : model_step
      logic c, p, eh;
      c  = m_s2[m_src];
      p  = m_prev[m_src];
      eh = (m_dir == 2'b00) ? (p & !c) : (m_dir == 2'b01) ? (!p & c) : (p ^ c);
      if (stop) m_st = 0;
      else if (m_st == 0 && start) begin
        m_hw = hw; m_lvl = lvl; m_dir = dir; m_src = src;
        m_st = (!hw || (lvl && dir[1])) ? 2 : (lvl ? 3 : 1);
      end else if (m_st == 1 && eh) m_st = 2;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = {cmp, pin};
    end
  end

  function automatic logic [1:0] model_out();
    logic c, mt;
    case (m_st)
      1: return 2'b01;
      2: return 2'b10;
      3: begin
        c  = m_s2[m_src];
        mt = (m_dir == 2'b00) ? !c : (m_dir == 2'b01) ? c : 1'b1;
        return {mt, !mt};
      end
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(string tag, logic [1:0] exp);
    checks++;
    if ({en, wt} !== exp) begin
      fails++;
      $display("FAIL %s: {en,wait} actual=%b expected=%b at %0t", tag, {en, wt}, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      case (m_st)
        1:       chk("R3 model", model_out());
        2:       chk("R5 model", model_out());
        3:       chk("R6 model", model_out());
        default: chk("R1 model", model_out());
      endcase
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_start();
    start = 1'b1; tick(1); start = 1'b0;
  endtask
  task automatic pulse_stop();
    stop = 1'b1; tick(1); stop = 1'b0;
  endtask
  task automatic set_cfg(logic h, logic l, logic [1:0] d, logic s);
    hw = h; lvl = l; dir = d; src = s;
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    chk("R1 reset", 2'b00);

    set_cfg(0, 0, 2'b00, 0);
    pulse_start(); chk("R2 sw start", 2'b10);
    tick(3);       chk("R2 sw hold", 2'b10);
    pulse_stop();  chk("R9 stop", 2'b00);

    pin = 1; tick(4);
    set_cfg(1, 0, 2'b00, 0);
    pulse_start(); chk("R3 armed", 2'b01);
    tick(3);       chk("R3 still armed", 2'b01);
    pin = 0; tick(2); chk("R3 before latency", 2'b01);
    tick(1);       chk("R3 fall fires", 2'b10);
    pin = 1; tick(3); pin = 0; tick(3);
    chk("R5 edge latched", 2'b10);
    pulse_stop();

    pin = 1; tick(4); pin = 0; tick(4);
    pulse_start(); tick(8);
    chk("R4 stale edge ignored", 2'b01);
    pin = 1; tick(4);
    chk("R3 wrong direction", 2'b01);
    pulse_stop();

    set_cfg(1, 0, 2'b10, 0); tick(2);
    pulse_start(); chk("R3 any armed", 2'b01);
    pin = 0; tick(3); chk("R3 any fires", 2'b10);
    pulse_stop();

    set_cfg(1, 1, 2'b00, 0);
    pulse_start(); chk("R6 low runs", 2'b10);
    pin = 1; tick(1); chk("R6 latency", 2'b10);
    tick(1);       chk("R6 high pauses", 2'b01);
    pin = 0; tick(2); chk("R6 resumes", 2'b10);
    pulse_stop();

    set_cfg(1, 1, 2'b01, 0);
    pulse_start(); chk("R6 pos low waits", 2'b01);
    pin = 1; tick(2); chk("R6 pos high runs", 2'b10);
    pulse_stop();

    set_cfg(1, 1, 2'b10, 0);
    pulse_start(); chk("R7 level any", 2'b10);
    pin = 0; tick(3); chk("R7 ignores low", 2'b10);
    pin = 1; tick(3); chk("R7 ignores high", 2'b10);
    pulse_stop();

    cmp = 0; tick(3);
    set_cfg(1, 0, 2'b01, 1);
    pulse_start(); chk("R8 cmp armed", 2'b01);
    pin = 0; tick(3); pin = 1; tick(4);
    chk("R8 pin ignored", 2'b01);
    cmp = 1; tick(2); chk("R8 cmp latency", 2'b01);
    tick(1);       chk("R8 cmp fires", 2'b10);
    pulse_stop();
    set_cfg(1, 1, 2'b01, 1);
    pulse_start(); chk("R8 cmp level", 2'b10);
    pin = 0; tick(3); chk("R8 pin level ignored", 2'b10);
    pulse_stop();
    cmp = 0; tick(3);

    set_cfg(0, 0, 2'b00, 0);
    start = 1; stop = 1; tick(1); start = 0; stop = 0;
    chk("R9 stop wins", 2'b00);
    set_cfg(1, 0, 2'b10, 0);
    pulse_start(); pin = 1; tick(3);
    chk("R3 fires before restart", 2'b10);
    pulse_stop(); pulse_start();
    chk("R9 restart waits", 2'b01);
    pulse_stop();

    pin = 0; tick(3);
    set_cfg(1, 1, 2'b00, 0);
    pulse_start(); chk("R10 level start", 2'b10);
    set_cfg(0, 0, 2'b01, 1); tick(2);
    chk("R10 cfg change ignored", 2'b10);
    pulse_start(); chk("R10 restart ignored", 2'b10);
    pin = 1; tick(2);
    chk("R10 still level neg", 2'b01);
    pulse_stop();

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) pin = ~pin;
      if ($urandom_range(7) == 0) cmp = ~cmp;
      start = ($urandom_range(15) == 0);
      stop  = ($urandom_range(39) == 0);
      if ($urandom_range(9) == 0)
        set_cfg(1'($urandom_range(1)), 1'($urandom_range(1)),
                2'($urandom_range(3)), 1'($urandom_range(1)));
      tick(1);
    end
    start = 0; stop = 0;
    tick(2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule